// File: doc/BRIEF.md
# Two-Wire Controller Command-Word Bridge

This block lets a host reach the byte-wide internal registers of a two-wire serial controller through one 64-bit command word. Software writes the word with the start flag (bit 63) set. The word carries an operation code, a register selector, a direction flag and a data byte. The bridge decodes the word and makes one access on a simple request interface toward the controller. When the access ends, the bridge clears bit 63. For a read, it also places the returned byte in bits 7:0 of the same word. Software polls the word until bit 63 reads back as zero.

A second, independent host register holds the interrupt-enable and line-override bits for the controller. A host strobe with a one-bit port select chooses between the command word and this register, for writes and for read-back.

Top module: `twsi_csr_bridge`

## Requirements
- R1: After reset, the command word and the interrupt register both read as zero, `core_req_o` is low, `core_sel_o` is 0 and `irq_en_o` is low.
- R2: A host write with `host_sel`=0 and bit 63 set, made while bit 63 of the stored word is clear, stores the whole word and starts an access. Bit 63 reads back as 1 until that access completes.
- R3: Bits 60:57 are the operation code and bit 56 is the read flag. Code 4'b0100 targets the clock-high-period register (`core_sel_o`=5). Code 4'b0110 targets the extended group, where bits 34:32 select the register: 1 is data (`core_sel_o`=1), 2 is control (2), and 3 is clock-control for a write (3) or status for a read (4). Selector 7 is the reset strobe (6) and is valid only for a write. `core_we_o` is the inverse of the read flag.
- R4: Each decodable access raises `core_req_o` for exactly one cycle, in the first cycle after acceptance. For a write, `core_wdata_o` carries bits 7:0. `core_sel_o` and `core_we_o` stay stable for the whole access.
- R5: A decodable access completes ACC_CYCLES cycles after acceptance, so bit 63 reads as 1 for exactly ACC_CYCLES cycles. Any other code or selector completes after one cycle and makes no request.
- R6: When a decodable read completes, bits 7:0 take the `core_rdata_i` value of the final access cycle. A read that cannot be decoded returns 0x00. Bits 62:8 are unchanged.
- R7: When a write completes, only bit 63 changes. Bits 62:0 are unchanged.
- R8: A command-word write made while bit 63 is set is ignored. The access in flight completes with its own target, data and result.
- R9: A command-word write with bit 63 clear stores the word but starts no access.
- R10: A write with `host_sel`=1 stores the low INT_W bits into the interrupt register, which reads back zero-extended. `irq_en_o` is bit 6 of that register, so writing 0x40 enables the interrupt and writing 0 disables it. This register does not affect the command word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_sel | input | 1 | 0 selects the command word, 1 selects the interrupt register |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Read-back of the selected register |
| core_req_o | output | 1 | One-cycle access request to the controller |
| core_we_o | output | 1 | Access is a write |
| core_sel_o | output | 3 | Internal register target code (0 when idle) |
| core_wdata_o | output | 8 | Write byte for the controller |
| core_rdata_i | input | 8 | Read byte from the controller for the current target |
| irq_en_o | output | 1 | Controller interrupt enable |
| int_reg_o | output | INT_W (12) | Full interrupt/override register contents |

## Verification
The properties take for granted that `core_rdata_i` depends only on the target the bridge presents, and that the host writes at most one register per cycle. The bench models the controller as a small byte array, indexed combinationally by `core_sel_o` and updated on each write request. It changes every input on the falling edge. The main sweep covers every operation code, every selector and both directions. A separate case writes a second command while an access is in flight, then reads the controller back through the bridge.

// File: rtl/twsi_br_pkg.sv
package twsi_br_pkg;

  localparam int CMD_W    = 64;
  localparam int VLD_BIT  = 63;
  localparam int RD_BIT   = 56;
  localparam int OP_MSB   = 60;
  localparam int OP_LSB   = 57;
  localparam int RSEL_MSB = 34;
  localparam int RSEL_LSB = 32;
  localparam int BYTE_W   = 8;

  localparam logic [3:0] OP_CLK_HIGH = 4'b0100;
  localparam logic [3:0] OP_EXT      = 4'b0110;

  localparam logic [2:0] RSEL_DATA     = 3'd1;
  localparam logic [2:0] RSEL_CTL      = 3'd2;
  localparam logic [2:0] RSEL_CLK_STAT = 3'd3;
  localparam logic [2:0] RSEL_RESET    = 3'd7;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_DATA   = 3'd1,
    TGT_CTL    = 3'd2,
    TGT_CLKCTL = 3'd3,
    TGT_STATUS = 3'd4,
    TGT_CLKHI  = 3'd5,
    TGT_RESET  = 3'd6
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic we;
    logic known;
  } dec_t;

endpackage

// File: rtl/twsi_br_rst_sync.sv
module twsi_br_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/twsi_br_decode.sv
module twsi_br_decode
  import twsi_br_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic [2:0] rsel_i,
  input  logic       rd_i,
  output dec_t       dec_o
);

  tgt_e tgt;

  always_comb begin
    tgt = TGT_NONE;
    case (op_i)
      OP_CLK_HIGH: tgt = TGT_CLKHI;
      OP_EXT: begin
        case (rsel_i)
          RSEL_DATA:     tgt = TGT_DATA;
          RSEL_CTL:      tgt = TGT_CTL;
          RSEL_CLK_STAT: tgt = rd_i ? TGT_STATUS : TGT_CLKCTL;
          RSEL_RESET:    tgt = rd_i ? TGT_NONE : TGT_RESET;
          default:       tgt = TGT_NONE;
        endcase
      end
      default: tgt = TGT_NONE;
    endcase
  end

  always_comb begin
    dec_o.tgt   = tgt;
    dec_o.known = (tgt != TGT_NONE);
    dec_o.we    = (tgt != TGT_NONE) && !rd_i;
  end

endmodule

// File: rtl/twsi_br_seq.sv
module twsi_br_seq #(
  parameter int ACC_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic known_i,
  output logic active_o,
  output logic req_o,
  output logic done_o
);

  localparam int CW = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(ACC_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_BUSY} st_e;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          st_en, cnt_en;

  assign active_o = (st_q == ST_BUSY);
  assign done_o   = active_o && (!known_i || (cnt_q == '0));
  assign req_o    = active_o && known_i && (cnt_q == CNT_TOP);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    st_en  = 1'b0;
    cnt_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_BUSY;
          st_en  = 1'b1;
          cnt_d  = CNT_TOP;
          cnt_en = 1'b1;
        end
      end
      ST_BUSY: begin
        if (done_o) begin
          st_d  = ST_IDLE;
          st_en = 1'b1;
        end else begin
          cnt_d  = cnt_q - CW'(1);
          cnt_en = 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        st_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      if (st_en)  st_q  <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/twsi_br_csr.sv
module twsi_br_csr
  import twsi_br_pkg::*;
#(
  parameter int INT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_i,
  input  logic              host_sel_i,
  input  logic [CMD_W-1:0]  host_wdata_i,
  input  logic              done_i,
  input  logic              ret_en_i,
  input  logic [BYTE_W-1:0] ret_byte_i,
  output logic [CMD_W-1:0]  cmd_q_o,
  output logic [INT_W-1:0]  int_q_o,
  output logic              start_o
);

  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             cmd_we, cmd_en, int_we;

  assign cmd_we  = host_wr_i && !host_sel_i && !cmd_q[VLD_BIT];
  assign start_o = cmd_we && host_wdata_i[VLD_BIT];
  assign int_we  = host_wr_i && host_sel_i;
  assign cmd_en  = cmd_we || done_i;

  always_comb begin
    cmd_d = cmd_q;
    if (cmd_we) begin
      cmd_d = host_wdata_i;
    end else if (done_i) begin
      cmd_d[VLD_BIT] = 1'b0;
      if (ret_en_i) cmd_d[BYTE_W-1:0] = ret_byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      int_q_o <= '0;
    end else begin
      if (cmd_en) cmd_q   <= cmd_d;
      if (int_we) int_q_o <= host_wdata_i[INT_W-1:0];
    end
  end

  assign cmd_q_o = cmd_q;

endmodule

// File: rtl/twsi_csr_bridge.sv
module twsi_csr_bridge
  import twsi_br_pkg::*;
#(
  parameter int ACC_CYCLES = 3,
  parameter int INT_W      = 12,
  parameter int IRQ_EN_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              core_req_o,
  output logic              core_we_o,
  output logic [2:0]        core_sel_o,
  output logic [7:0]        core_wdata_o,
  input  logic [7:0]        core_rdata_i,
  output logic              irq_en_o,
  output logic [INT_W-1:0]  int_reg_o
);

  logic              rst_sync_n;
  logic [CMD_W-1:0]  csr_word;
  logic              csr_valid;
  logic [INT_W-1:0]  int_q;
  logic              start, active, done, drive;
  logic [BYTE_W-1:0] ret_byte;
  dec_t              dec;

  twsi_br_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  twsi_br_decode u_dec (
    .op_i   (csr_word[OP_MSB:OP_LSB]),
    .rsel_i (csr_word[RSEL_MSB:RSEL_LSB]),
    .rd_i   (csr_word[RD_BIT]),
    .dec_o  (dec)
  );

  twsi_br_seq #(.ACC_CYCLES(ACC_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start),
    .known_i  (dec.known),
    .active_o (active),
    .req_o    (core_req_o),
    .done_o   (done)
  );

  assign ret_byte = dec.known ? core_rdata_i : '0;

  twsi_br_csr #(.INT_W(INT_W)) u_csr (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .host_wr_i    (host_wr),
    .host_sel_i   (host_sel),
    .host_wdata_i (host_wdata),
    .done_i       (done),
    .ret_en_i     (csr_word[RD_BIT]),
    .ret_byte_i   (ret_byte),
    .cmd_q_o      (csr_word),
    .int_q_o      (int_q),
    .start_o      (start)
  );

  assign csr_valid    = csr_word[VLD_BIT];
  assign drive        = active && dec.known;
  assign core_sel_o   = drive ? dec.tgt : TGT_NONE;
  assign core_we_o    = drive && dec.we;
  assign core_wdata_o = (drive && dec.we) ? csr_word[BYTE_W-1:0] : '0;
  assign host_rdata   = host_sel ? CMD_W'(int_q) : csr_word;
  assign irq_en_o     = int_q[IRQ_EN_BIT];
  assign int_reg_o    = int_q;

endmodule

// File: rtl/twsi_br_chk.sv
module twsi_br_chk #(
  parameter int ACC_CYCLES = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_valid,
  input logic [63:0] csr_word,
  input logic        core_req_o,
  input logic        core_we_o,
  input logic [2:0]  core_sel_o
);

  localparam int VW = $clog2(ACC_CYCLES + 2) + 1;

  logic [VW-1:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt <= '0;
    end else if (csr_valid) begin
      if (vcnt != {VW{1'b1}}) vcnt <= vcnt + VW'(1);
    end else begin
      vcnt <= '0;
    end
  end

  assert_no_req_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_valid |-> !core_req_o);

  assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_o |=> !core_req_o);

  assert_target_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && $past(csr_valid)) |-> ($stable(core_sel_o) && $stable(core_we_o)));

  assert_word_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && $past(csr_valid)) |-> $stable(csr_word));

  assert_reset_is_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sel_o == 3'd6) |-> core_we_o);

  assert_status_is_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sel_o == 3'd4) |-> !core_we_o);

  assert_bounded_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid |-> (vcnt < VW'(ACC_CYCLES)));

endmodule

bind twsi_csr_bridge twsi_br_chk #(.ACC_CYCLES(ACC_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .csr_valid  (csr_valid),
  .csr_word   (csr_word),
  .core_req_o (core_req_o),
  .core_we_o  (core_we_o),
  .core_sel_o (core_sel_o)
);

// File: tb/twsi_csr_bridge_bench.sv
module twsi_csr_bridge_bench;

  localparam int ACC   = 3;
  localparam int INT_W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        core_req_o, core_we_o, irq_en_o;
  logic [2:0]  core_sel_o;
  logic [7:0]  core_wdata_o, core_rdata_i;
  logic [INT_W-1:0] int_reg_o;

  always #4 clk = ~clk;

  twsi_csr_bridge #(.ACC_CYCLES(ACC), .INT_W(INT_W)) u_twsi_csr_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_req_o(core_req_o), .core_we_o(core_we_o), .core_sel_o(core_sel_o),
    .core_wdata_o(core_wdata_o), .core_rdata_i(core_rdata_i),
    .irq_en_o(irq_en_o), .int_reg_o(int_reg_o)
  );

  // controller model: byte per target code
  logic [7:0] cm [0:7];
  int         nreq;
  logic [2:0] last_sel;
  logic       last_we;
  logic [7:0] last_wd;
  int         nerr = 0;
  int         nchk = 0;
  bit         finished = 0;

  assign core_rdata_i = cm[core_sel_o];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) cm[i] <= 8'h21 + 8'(i * 19);
      cm[4]    <= 8'hF8;
      nreq     <= 0;
      last_sel <= '0;
      last_we  <= 1'b0;
      last_wd  <= '0;
    end else if (core_req_o) begin
      nreq     <= nreq + 1;
      last_sel <= core_sel_o;
      last_we  <= core_we_o;
      last_wd  <= core_wdata_o;
      if (core_we_o) cm[core_sel_o] <= core_wdata_o;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(logic sel, logic [63:0] data);
    @(negedge clk);
    host_sel   = sel;
    host_wdata = data;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr  = 1'b0;
    host_sel = 1'b0;
    #1;
  endtask

  task automatic poll(output int lat);
    lat = 0;
    while (host_rdata[63] && lat < 50) begin
      lat++;
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [2:0] exp_tgt(int op, int s, int rd);
    if (op == 4) return 3'd5;
    if (op == 6) begin
      if (s == 1) return 3'd1;
      if (s == 2) return 3'd2;
      if (s == 3) return (rd != 0) ? 3'd4 : 3'd3;
      if (s == 7 && rd == 0) return 3'd6;
    end
    return 3'd0;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog R5 actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int lat, bc;
    logic [63:0] cmd, w, a, b;
    logic [2:0]  t;
    logic [7:0]  eb, old;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 cmd word", host_rdata, 64'h0);
    chk("R1 req", {63'h0, core_req_o}, 64'h0);
    chk("R1 sel", {61'h0, core_sel_o}, 64'h0);
    chk("R1 irq", {63'h0, irq_en_o}, 64'h0);
    host_sel = 1'b1; #1;
    chk("R1 int reg", host_rdata, 64'h0);
    host_sel = 1'b0; #1;

    // R2..R7 sweep over every code, selector and direction
    for (int op = 0; op < 16; op++) begin
      for (int s = 0; s < 8; s++) begin
        for (int rd = 0; rd < 2; rd++) begin
          cmd = 64'h0;
          cmd[63]    = 1'b1;
          cmd[62:61] = 2'b01;
          cmd[60:57] = 4'(op);
          cmd[56]    = rd[0];
          cmd[55:35] = 21'h1A5A5;
          cmd[34:32] = 3'(s);
          cmd[31:8]  = 24'hC3A5F0;
          cmd[7:0]   = {4'(op), 3'(s), rd[0]};
          t  = exp_tgt(op, s, rd);
          eb = (t != 0) ? cm[t] : 8'h00;
          bc = nreq;
          host_write(1'b0, cmd);
          chk("R2 valid set", {63'h0, host_rdata[63]}, 64'h1);
          poll(lat);
          chk("R5 latency", 64'(lat), (t != 0) ? 64'(ACC) : 64'd1);
          chk("R4 request count", 64'(nreq - bc), (t != 0) ? 64'd1 : 64'd0);
          if (t != 0) begin
            chk("R3 target", {61'h0, last_sel}, {61'h0, t});
            chk("R3 direction", {63'h0, last_we}, {63'h0, ~rd[0]});
            if (rd == 0) chk("R4 write byte", {56'h0, last_wd}, {56'h0, cmd[7:0]});
          end
          w = {1'b0, cmd[62:0]};
          if (rd != 0) begin
            w[7:0] = eb;
            chk("R6 read word", host_rdata, w);
          end else begin
            chk("R7 write word", host_rdata, w);
          end
        end
      end
    end

    // R8 write during access is ignored
    old = cm[1];
    a = 64'h8800_0000_0000_0011;
    b = 64'h8C00_0001_0000_0022;
    bc = nreq;
    @(negedge clk);
    host_wdata = a; host_wr = 1'b1;
    @(negedge clk);
    host_wdata = b; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; #1;
    poll(lat);
    chk("R8 latency unchanged", 64'(lat + 1), 64'(ACC));
    chk("R8 single request", 64'(nreq - bc), 64'd1);
    chk("R8 first target kept", {61'h0, last_sel}, 64'd5);
    chk("R8 first data kept", {56'h0, last_wd}, 64'h11);
    chk("R8 word kept", host_rdata, {1'b0, a[62:0]});
    host_write(1'b0, 64'h8D00_0001_0000_0000);
    poll(lat);
    chk("R8 data reg untouched", {56'h0, host_rdata[7:0]}, {56'h0, old});

    // R9 stored word without start flag
    w = 64'h0800_0001_0000_0077;
    bc = nreq;
    host_write(1'b0, w);
    chk("R9 stored", host_rdata, w);
    repeat (5) @(negedge clk);
    #1;
    chk("R9 no request", 64'(nreq - bc), 64'd0);
    chk("R9 still stored", host_rdata, w);

    // R10 interrupt register
    host_write(1'b1, 64'hFFFF_0000_0000_0040);
    chk("R10 irq enabled", {63'h0, irq_en_o}, 64'h1);
    host_sel = 1'b1; #1;
    chk("R10 readback", host_rdata, 64'h40);
    host_sel = 1'b0; #1;
    chk("R10 cmd unaffected", host_rdata, w);
    host_write(1'b1, 64'h0000_0000_0000_0300);
    chk("R10 override bits", {52'h0, int_reg_o}, 64'h300);
    chk("R10 irq off with 0x300", {63'h0, irq_en_o}, 64'h0);
    host_write(1'b1, 64'h0);
    chk("R10 disabled", {52'h0, int_reg_o}, 64'h0);

    finished = 1;
    summary();
    $finish;
  end

endmodule